// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This block brings up a programmable device after power-on. Once reset is released it fetches a fixed area of option words from a word-addressed flash and decodes the configuration settings it holds. It latches a 3-bit page selector once, to choose which of eight stored images to send. Using the page table in the option area it finds where that image starts and how long it is. It then holds off until the target device signals that it can accept data. Once it can, the block streams the image words, in order, to a downstream serializer.

Two valid/ready channels face the flash: a request channel carrying a word address, and a response channel carrying the data. At most one request is in flight at a time. A request, once valid, keeps its address until it is accepted. The block may refuse a response by holding `rd_rsp_ready` low, and the flash must then hold the word stable. The image leaves on a third valid/ready channel. When `out_ready` is low, `out_valid` and `out_data` hold their values. That back-pressure passes straight through to the flash response channel, so no word is ever buffered twice.

The target reports two plain levels. `tgt_ok` goes low when the target detects an error. `tgt_done` goes high when the target has finished loading. A fall of `tgt_ok` during streaming aborts the transfer and sets a sticky error flag, and the image is sent again from its start once the target is ready. A rise of `tgt_done` ends streaming for good.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, `status` is 0 (idle), `rd_req_valid`, `out_valid` and `err_flag` are 0.
- R2: After reset, the first 32 flash requests go to word addresses 0x08000 to 0x0801F in increasing order. They are issued one at a time, and each request holds its address until accepted.
- R3: When the option fetch ends, the option word at offset 0 is decoded as follows: bits [1:0] appear on `cfg_scheme`, bits [5:2] on `cfg_clkdiv` and bit 6 on `cfg_decomp`.
- R4: `page_sel` is sampled only in the first clock cycle after reset is released, and later changes on it have no effect on which image is sent.
- R5: For sampled page p, the option word at offset 1+2p gives the image start address and the word at offset 2+2p gives its length in words. The image is read from consecutive addresses starting at that start address, and each word is delivered on `out_data` unchanged and in address order.
- R6: No image read is requested unless `tgt_ok` is 1 and `tgt_done` is 0, and `status` is 2 (waiting) while the block holds off.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged, unless the target aborts or finishes. Under back-pressure every image word is delivered exactly once.
- R8: If `tgt_ok` falls while `status` is 3 (streaming), `status` shows 5 (error) for one cycle and then 2. `err_flag` rises and stays 1 until reset, and the image is sent again from its first word once the target is ready.
- R9: When `tgt_done` is 1 during streaming, no further word is delivered, and `status` becomes 4 (done) and stays 4 until reset.
- R10: A page with length 0 issues no image reads and delivers no word, and `status` stays 3 until `tgt_done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 3 | Image page selector, sampled once after reset |
| tgt_ok | input | 1 | Target healthy (low = target error) |
| tgt_done | input | 1 | Target finished loading |
| rd_req_valid | output | 1 | Flash read request valid |
| rd_req_ready | input | 1 | Flash accepts request |
| rd_req_addr | output | 20 | Flash word address |
| rd_rsp_valid | input | 1 | Flash read data valid |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | 16 | Flash read data |
| out_valid | output | 1 | Image word valid |
| out_ready | input | 1 | Serializer accepts word |
| out_data | output | 16 | Image word |
| cfg_scheme | output | 2 | Decoded configuration scheme code |
| cfg_clkdiv | output | 4 | Decoded configuration clock setting |
| cfg_decomp | output | 1 | Decoded decompression enable |
| err_flag | output | 1 | Sticky abort indication |
| status | output | 3 | 0 idle, 1 options, 2 waiting, 3 streaming, 4 done, 5 error |

## Verification
The assertions check several rules on every cycle. A pending request holds its address, and the option capture never runs past its 32 words. No request is issued while the block waits for the target. The image output holds under back-pressure, the error state always passes straight to waiting, and both the done state and the error flag are sticky. Only the bench scenarios can show the rest, because they need the whole flash content and transaction history. These are the exact address order of the option and image reads, the decoded fields, the page-table lookup for every page, the immunity to later `page_sel` changes, and the full resend after an abort.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPTS   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_STREAM = 3'd3,
    ST_DONE   = 3'd4,
    ST_ERROR  = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_REQ  = 2'd1,
    RD_RSP  = 2'd2
  } rd_state_t;

  typedef struct packed {
    logic [1:0] scheme;
    logic [3:0] clkdiv;
    logic       decomp;
  } opt_cfg_t;

endpackage

// File: rtl/cfg_flash_reader.sv
module cfg_flash_reader
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  input  logic              abort,
  input  logic              sink_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              idle
);

  rd_state_t         st;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  remain;
  logic              drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr   <= '0;
      remain <= '0;
      drop   <= 1'b0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (start && !abort && (len != '0)) begin
            addr   <= base;
            remain <= len;
            st     <= RD_REQ;
          end
        end
        RD_REQ: begin
          if (abort) begin
            st <= RD_IDLE;
          end else if (req_ready) begin
            addr <= addr + ADDR_W'(1);
            st   <= RD_RSP;
          end
        end
        RD_RSP: begin
          if (rsp_valid && rsp_ready) begin
            drop   <= 1'b0;
            remain <= remain - CNT_W'(1);
            if (drop || abort || (remain == CNT_W'(1))) st <= RD_IDLE;
            else st <= RD_REQ;
          end else if (abort) begin
            drop <= 1'b1;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid  = (st == RD_REQ) && !abort;
    req_addr   = addr;
    rsp_ready  = (st == RD_RSP) && (drop || abort || sink_ready);
    word_valid = (st == RD_RSP) && rsp_valid && !drop && !abort;
    word_data  = rsp_data;
    idle       = (st == RD_IDLE);
  end

  // R2: a pending request keeps its address until accepted
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (abort || (req_valid && $stable(req_addr))));

  // R2: never a request while a response is awaited
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

endmodule

// File: rtl/cfg_opt_store.sv
module cfg_opt_store
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 3,
  parameter int OPT_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [PAGE_W-1:0] page,
  output opt_cfg_t          cfg,
  output logic [DATA_W-1:0] page_start,
  output logic [DATA_W-1:0] page_len
);

  localparam int PAGES = 2 ** PAGE_W;
  localparam int TBL_N = 2 * PAGES;
  localparam int IDX_W = $clog2(OPT_WORDS + 1);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] tbl [TBL_N];
  opt_cfg_t          cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      cfg_q <= '0;
    end else if (clear) begin
      idx <= '0;
    end else if (cap_valid) begin
      idx <= idx + IDX_W'(1);
      if (idx == '0) begin
        cfg_q.scheme <= cap_data[1:0];
        cfg_q.clkdiv <= cap_data[5:2];
        cfg_q.decomp <= cap_data[6];
      end
    end
  end

  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n) tbl[g] <= '0;
      else if (cap_valid && !clear && (idx == IDX_W'(g + 1))) tbl[g] <= cap_data;
    end
  end

  always_comb begin
    cfg        = cfg_q;
    page_start = tbl[{page, 1'b0}];
    page_len   = tbl[{page, 1'b1}];
  end

  // R2: capture never runs past the option area
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (idx < IDX_W'(OPT_WORDS)));

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              tgt_ok,
  input  logic              tgt_done,
  input  logic              rd_idle,
  output seq_state_t        st,
  output logic [PAGE_W-1:0] page,
  output logic              rd_start,
  output logic              rd_opts,
  output logic              rd_abort,
  output logic              err_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      page     <= '0;
      err_flag <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          page <= page_sel;
          st   <= ST_OPTS;
        end
        ST_OPTS:   if (rd_idle) st <= ST_WAIT;
        ST_WAIT:   if (tgt_ok && !tgt_done && rd_idle) st <= ST_STREAM;
        ST_STREAM: begin
          if (!tgt_ok) begin
            st       <= ST_ERROR;
            err_flag <= 1'b1;
          end else if (tgt_done) begin
            st <= ST_DONE;
          end
        end
        ST_ERROR:  st <= ST_WAIT;
        ST_DONE:   st <= ST_DONE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_start = 1'b0;
    rd_opts  = 1'b0;
    rd_abort = 1'b0;
    case (st)
      ST_IDLE: begin
        rd_start = 1'b1;
        rd_opts  = 1'b1;
      end
      ST_WAIT:   rd_start = tgt_ok && !tgt_done && rd_idle;
      ST_STREAM: rd_abort = !tgt_ok || tgt_done;
      ST_DONE:   rd_abort = 1'b1;
      default: ;
    endcase
  end

  // R8: error state lasts one cycle and leads to waiting
  assert_err_to_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERROR) |=> (st == ST_WAIT));

  // R8: error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R9: done is final until reset
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (st == ST_DONE));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 3,
  parameter int OPT_WORDS = 32,
  parameter int OPT_BASE  = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              tgt_ok,
  input  logic              tgt_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        cfg_scheme,
  output logic [3:0]        cfg_clkdiv,
  output logic              cfg_decomp,
  output logic              err_flag,
  output logic [2:0]        status
);

  localparam int PAD_W = ADDR_W - DATA_W;

  seq_state_t        st;
  logic [PAGE_W-1:0] page;
  logic              rd_start, rd_opts, rd_abort, rd_idle;
  logic              word_valid, sink_ready;
  logic [DATA_W-1:0] word_data;
  logic [DATA_W-1:0] page_start, page_len;
  logic [ADDR_W-1:0] rd_base;
  logic [DATA_W-1:0] rd_len;
  opt_cfg_t          cfg;

  cfg_seq_fsm #(.PAGE_W(PAGE_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .tgt_ok(tgt_ok),
    .tgt_done(tgt_done), .rd_idle(rd_idle), .st(st), .page(page),
    .rd_start(rd_start), .rd_opts(rd_opts), .rd_abort(rd_abort),
    .err_flag(err_flag)
  );

  always_comb begin
    rd_base    = rd_opts ? ADDR_W'(OPT_BASE) : {{PAD_W{1'b0}}, page_start};
    rd_len     = rd_opts ? DATA_W'(OPT_WORDS) : page_len;
    sink_ready = (st == ST_OPTS) ? 1'b1 : out_ready;
  end

  cfg_flash_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(DATA_W)) i_reader (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .base(rd_base), .len(rd_len),
    .abort(rd_abort), .sink_ready(sink_ready),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready), .rsp_data(rd_rsp_data),
    .word_valid(word_valid), .word_data(word_data), .idle(rd_idle)
  );

  cfg_opt_store #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .OPT_WORDS(OPT_WORDS)) i_opts (
    .clk(clk), .rst_n(rst_n), .clear(rd_start && rd_opts),
    .cap_valid(word_valid && (st == ST_OPTS)), .cap_data(word_data),
    .page(page), .cfg(cfg), .page_start(page_start), .page_len(page_len)
  );

  always_comb begin
    out_valid  = word_valid && (st == ST_STREAM);
    out_data   = word_data;
    cfg_scheme = cfg.scheme;
    cfg_clkdiv = cfg.clkdiv;
    cfg_decomp = cfg.decomp;
    status     = st;
  end

  // R6: no flash request while holding off for the target
  assert_wait_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !rd_req_valid);

  // R7: output holds under back-pressure unless aborted or finished
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!tgt_ok || tgt_done || (out_valid && $stable(out_data))));

  // R9: nothing delivered once done
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> !out_valid);

endmodule

// File: tb/test_cfg_seq_ctrl.sv
module test_cfg_seq_ctrl;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  page_sel = 3'd0;
  logic        tgt_ok = 1'b1;
  logic        tgt_done = 1'b0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [19:0] rd_req_addr;
  logic [15:0] rd_rsp_data;
  logic        out_valid, out_ready;
  logic [15:0] out_data;
  logic [1:0]  cfg_scheme;
  logic [3:0]  cfg_clkdiv;
  logic        cfg_decomp, err_flag;
  logic [2:0]  status;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_seq_ctrl i_cfg_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .tgt_ok(tgt_ok),
    .tgt_done(tgt_done), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_scheme(cfg_scheme), .cfg_clkdiv(cfg_clkdiv),
    .cfg_decomp(cfg_decomp), .err_flag(err_flag), .status(status)
  );

  // flash content
  logic [15:0] opt_mem [32];
  logic        bp_mode = 1'b0;

  function automatic logic [15:0] img(input logic [19:0] a);
    return (a[15:0] * 16'd7) ^ 16'h3C3C;
  endfunction

  function automatic logic [15:0] fmem(input logic [19:0] a);
    if (a >= 20'h08000 && a < 20'h08020) return opt_mem[a[4:0]];
    return img(a);
  endfunction

  function automatic logic [15:0] pstart(input int p);
    return 16'h0200 + 16'(p * 64);
  endfunction

  function automatic int plen(input int p);
    return (p == 7) ? 0 : p + 2;
  endfunction

  // flash model with varying ready and latency
  int          tick = 0;
  logic        busy;
  int          lat;
  logic [19:0] paddr;
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= 16'h0;
      busy         <= 1'b0;
      lat          <= 0;
      out_ready    <= 1'b1;
    end else begin
      tick = tick + 1;
      rd_req_ready <= (tick % 3 != 1);
      out_ready    <= bp_mode ? (tick % 4 != 0) : 1'b1;
      if (rd_req_valid && rd_req_ready && !busy) begin
        busy  <= 1'b1;
        paddr <= rd_req_addr;
        lat   <= tick % 2;
      end
      if (busy && !rd_rsp_valid) begin
        if (lat == 0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= fmem(paddr);
        end else lat <= lat - 1;
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
        busy         <= 1'b0;
      end
    end
  end

  // transaction monitor
  logic [19:0] req_log [256];
  logic [15:0] out_log [256];
  int req_n, out_n;
  always @(posedge clk) begin
    if (!rst_n) begin
      req_n = 0;
      out_n = 0;
    end else begin
      if (rd_req_valid && rd_req_ready && req_n < 256) begin
        req_log[req_n] = rd_req_addr;
        req_n = req_n + 1;
      end
      if (out_valid && out_ready && out_n < 256) begin
        out_log[out_n] = out_data;
        out_n = out_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_opts(input int p);
    logic [3:0] cd;
    cd = 4'(p + 3);
    for (int i = 0; i < 32; i++) opt_mem[i] = 16'hEEEE ^ 16'(i);
    opt_mem[0] = {9'h1AB, p[0], cd, p[1:0]};
    for (int q = 0; q < 8; q++) begin
      opt_mem[1 + 2*q] = pstart(q);
      opt_mem[2 + 2*q] = 16'(plen(q));
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0;
    page_sel = 3'(p);
    repeat (3) @(negedge clk);
    chk(status == 3'd0 && !rd_req_valid && !out_valid && !err_flag,
        "R1 reset state", {status, err_flag}, 0);
    rst_n = 1'b1;
    chk(status == 3'd0 && !rd_req_valid && !out_valid, "R1 after release", status, 0);
    @(negedge clk);
    page_sel = ~3'(p);  // R4: later change must be ignored
  endtask

  task automatic wait_out(input int n, input int maxc);
    for (int c = 0; c < maxc && out_n < n; c++) @(negedge clk);
  endtask

  task automatic wait_status(input logic [2:0] s, input int maxc);
    for (int c = 0; c < maxc && status != s; c++) @(negedge clk);
  endtask

  task automatic chk_opt_reads;
    bit ok = 1'b1;
    int fa = 0;
    for (int i = 0; i < 32; i++)
      if (req_log[i] != 20'h08000 + 20'(i)) begin ok = 1'b0; fa = i; end
    chk(ok && req_n >= 32, "R2 option address order", int'(req_log[fa]), 'h8000 + fa);
  endtask

  task automatic chk_image(input int p, input int from, input string req);
    bit ok = 1'b1;
    int fi = 0;
    for (int i = 0; i < plen(p); i++)
      if (out_log[from + i] != img(20'(pstart(p)) + 20'(i))) begin ok = 1'b0; fi = i; end
    chk(ok, req, int'(out_log[from + fi]), int'(img(20'(pstart(p)) + 20'(fi))));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // sweep over all pages, back-pressure on odd pages
    for (int p = 0; p < 8; p++) begin
      load_opts(p);
      bp_mode = p[0];
      tgt_ok = 1'b1;
      tgt_done = 1'b0;
      do_reset(p);
      wait_status(3'd3, 2000);
      wait_out(plen(p), 2000);
      repeat (30) @(negedge clk);
      chk_opt_reads();
      chk(cfg_scheme == 2'(p) && cfg_clkdiv == 4'(p + 3) && cfg_decomp == p[0],
          "R3 option decode", {cfg_scheme, cfg_clkdiv, cfg_decomp}, p);
      chk(out_n == plen(p) && req_n == 32 + plen(p), "R7 word count", out_n, plen(p));
      begin
        bit ok = 1'b1;
        for (int i = 0; i < plen(p); i++)
          if (req_log[32 + i] != 20'(pstart(p)) + 20'(i)) ok = 1'b0;
        chk(ok, "R4 R5 image addresses from sampled page", int'(req_log[32]), int'(pstart(p)));
      end
      chk_image(p, 0, "R5 image data");
      if (plen(p) == 0)
        chk(status == 3'd3 && req_n == 32 && out_n == 0, "R10 empty page", status, 3);
      tgt_done = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(status == 3'd4, "R9 done state", status, 4);
      repeat (10) @(negedge clk);
      chk(status == 3'd4 && out_n == plen(p), "R9 done holds", out_n, plen(p));
    end

    // gating on target readiness
    load_opts(2);
    bp_mode = 1'b0;
    tgt_ok = 1'b0;
    tgt_done = 1'b0;
    do_reset(2);
    wait_status(3'd2, 2000);
    repeat (60) @(negedge clk);
    chk(req_n == 32 && status == 3'd2, "R6 hold while not ok", req_n, 32);
    tgt_ok = 1'b1;
    tgt_done = 1'b1;
    repeat (30) @(negedge clk);
    chk(req_n == 32 && status == 3'd2, "R6 hold while done high", req_n, 32);
    tgt_done = 1'b0;
    wait_out(plen(2), 2000);
    repeat (5) @(negedge clk);
    chk_image(2, 0, "R6 stream after ready");

    // abort and resend
    load_opts(4);
    bp_mode = 1'b1;
    tgt_ok = 1'b1;
    do_reset(4);
    wait_out(3, 3000);
    tgt_ok = 1'b0;
    @(negedge clk);
    chk(status == 3'd5 && err_flag, "R8 error state", status, 5);
    @(negedge clk);
    chk(status == 3'd2 && err_flag, "R8 back to waiting", status, 2);
    begin
      int mark;
      mark = out_n;
      repeat (20) @(negedge clk);
      chk(status == 3'd2 && out_n == mark, "R8 held while error", out_n, mark);
      tgt_ok = 1'b1;
      wait_out(mark + plen(4), 3000);
      repeat (10) @(negedge clk);
      chk(out_n == mark + plen(4), "R8 resend count", out_n - mark, plen(4));
      chk_image(4, mark, "R8 resend from first word");
      chk(err_flag, "R8 flag sticky", err_flag, 1);
    end

    // finish mid-stream
    load_opts(5);
    bp_mode = 1'b0;
    do_reset(5);
    chk(!err_flag, "R1 flag cleared by reset", err_flag, 0);
    wait_out(3, 3000);
    tgt_done = 1'b1;
    @(negedge clk);
    chk(status == 3'd4, "R9 stop mid-stream", status, 4);
    repeat (40) @(negedge clk);
    chk(out_n == 3 && status == 3'd4, "R9 no word after done", out_n, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule